// File: doc/BRIEF.md
# Masked Row Readback CRC

This block sequences a configuration readback of a programmable device through a JTAG scan engine. It folds every returned row into one CRC-32 digest. It does not drive TCK, TMS, TDI or TDO itself. It hands the engine one command at a time: an instruction scan, a data scan or a run of idle clocks. It then waits for the engine to acknowledge each command. During a row read the engine streams the captured row back as bytes, least significant bit first.

After a `start` pulse the block issues the enable instruction several times, with a long idle after each. It then issues the read instruction and walks the rows in ascending order. For each row it scans in the row address, idles, reads the row with TDI held high, and idles again. Rows whose length is not a multiple of eight end in a partial byte. That byte carries filler bits which must not reach the checksum. For this reason every returned byte is ANDed with a mask byte before it enters the CRC. The mask is taken from a small bank, and a per-row index selects which mask a row uses. The bank and the index table are captured at `start`.

Top module: `row_readback_crc`

## Requirements
- R1: After reset, and before any `start`, `done` is 0 and `eng_req` is 0.
- R2: Opcodes are IR scan = 0, DR scan = 1, idle = 2. The run begins with the enable instruction. This is an 8-bit IR scan of code 0xE8 with no pause, followed by an idle command of 800 clocks. The pair is repeated three times.
- R3: After the enables, the read instruction is issued: an 8-bit IR scan of code 0xEE with a pause length of 1.
- R4: Each row r starts with a 7-bit DR scan that carries address r XOR (r >> 1) and has a pause length of 20. An idle command of 100 clocks follows it.
- R5: Each row's data is then read by a DR scan of ROW_BITS bits with `eng_ones` = 1, followed by another 100-clock idle. Rows go in ascending order. `eng_ones` is 0 on every other command.
- R6: Byte b of row r is ANDed with mask byte `mask_bank[(m*BYTES + b)*8 +: 8]` before it enters the CRC, where m = `mask_pick[r*IDX_W +: IDX_W]`.
- R7: The CRC covers all BYTES = ceil(ROW_BITS/8) bytes of each row, including the partial last byte. Any further bytes the engine returns for that row are ignored. The CRC is reflected CRC-32 (polynomial 0xEDB88320), with an initial value of all ones, one byte per clock taken LSB first.
- R8: When the last row's final idle completes, `done` rises. `digest` equals the inverted CRC. Both hold without change until the next `start`.
- R9: A `start` pulse while a run is in progress has no effect.
- R10: The mask bank and index table are captured at `start`. Changes at their inputs during the run do not affect the digest.
- R11: Each command is a single-cycle `eng_req` pulse. The next command is issued only after `eng_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a readback run |
| mask_bank | input | NUM_MASKS*BYTES*8 | Mask bytes, mask m byte b at (m*BYTES+b)*8 |
| mask_pick | input | ROWS*IDX_W | Mask index per row |
| eng_req | output | 1 | One-cycle command strobe to the scan engine |
| eng_op | output | 2 | Command kind: 0 IR scan, 1 DR scan, 2 idle |
| eng_len | output | 16 | Scan length in bits or idle clock count |
| eng_data | output | 8 | Instruction code or row address to shift in |
| eng_pause | output | 8 | Clocks to spend in the pause state after the scan, 0 for none |
| eng_ones | output | 1 | Drive TDI high for the whole scan |
| eng_ack | input | 1 | Engine finished the current command |
| eng_rx_valid | input | 1 | A captured byte is present on eng_rx_byte |
| eng_rx_byte | input | 8 | Captured row byte, first bit in bit 0 |
| done | output | 1 | Digest is valid |
| digest | output | 32 | Final CRC-32 value |

## Verification
On every cycle, the embedded properties check four things. Command strobes are single pulses. No command is issued once the digest is ready. Scans with TDI held high happen only as full-row reads, and idle commands carry only the two allowed clock counts. The digest and the captured masks stay frozen outside their load points. Only the bench's scenarios can show the exact order and content of the command stream and the row addresses. The same holds for the arithmetic value of the digest under different masks, the removal of filler bits in the partial byte, and the handling of surplus bytes. It also holds for the fact that a late start or a change of mask inputs in mid-run leaves the result untouched.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {OP_IR = 2'd0, OP_DR = 2'd1, OP_IDLE = 2'd2} eng_op_t;

  typedef enum logic [2:0] {
    STP_EN_IR, STP_EN_IDLE, STP_RD_IR, STP_ADDR, STP_ADDR_IDLE, STP_DATA, STP_DATA_IDLE
  } step_t;

  typedef enum logic [1:0] {PH_OFF, PH_ISSUE, PH_WAIT, PH_END} phase_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte of reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  // Row address: Gray code of the row index
  function automatic logic [6:0] row_gray(input int unsigned r);
    logic [6:0] v;
    v = 7'(r);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/rbc_crc32.sv
module rbc_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic [7:0]  data,
  output logic [31:0] digest
);
  import rbc_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (step) crc_q <= crc32_byte(crc_q, data);
  end

  assign digest = ~crc_q;

endmodule

// File: rtl/rbc_mask_store.sv
module rbc_mask_store #(
  parameter int ROWS      = 4,
  parameter int BYTES     = 3,
  parameter int NUM_MASKS = 2,
  parameter int IDX_W     = 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int BYTE_W   = $clog2(BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_MASKS*BYTES*8-1:0] bank_in,
  input  logic [ROWS*IDX_W-1:0]        pick_in,
  input  logic [ROW_W-1:0]             row_idx,
  input  logic [BYTE_W-1:0]            byte_idx,
  output logic [7:0]                   mask_byte
);
  logic [NUM_MASKS*BYTES*8-1:0] bank_q;
  logic [ROWS*IDX_W-1:0]        pick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      pick_q <= '0;
    end else if (load) begin
      bank_q <= bank_in;
      pick_q <= pick_in;
    end
  end

  always_comb begin
    int sel;
    mask_byte = 8'h00;
    sel = int'(pick_q[int'(row_idx)*IDX_W +: IDX_W]);
    if (int'(byte_idx) < BYTES && sel < NUM_MASKS)
      mask_byte = bank_q[(sel*BYTES + int'(byte_idx))*8 +: 8];
  end

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(bank_q) && $stable(pick_q)));

endmodule

// File: rtl/rbc_seq.sv
module rbc_seq #(
  parameter int ROWS        = 4,
  parameter int ROW_BITS    = 20,
  parameter int EN_REPEAT   = 3,
  parameter int EN_WAIT     = 800,
  parameter int ROW_WAIT    = 100,
  parameter int ADDR_PAUSE  = 20,
  parameter logic [7:0] EN_CODE = 8'hE8,
  parameter logic [7:0] RD_CODE = 8'hEE,
  localparam int BYTES      = (ROW_BITS + 7) / 8,
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int BYTE_W     = $clog2(BYTES + 1),
  localparam int EN_W       = $clog2(EN_REPEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              eng_ack,
  input  logic              eng_rx_valid,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [15:0]       eng_len,
  output logic [7:0]        eng_data,
  output logic [7:0]        eng_pause,
  output logic              eng_ones,
  output logic              done,
  output logic              load_masks,
  output logic              crc_init,
  output logic              crc_step,
  output logic [ROW_W-1:0]  row_idx,
  output logic [BYTE_W-1:0] byte_idx
);
  import rbc_pkg::*;

  phase_t          phase;
  step_t           step;
  logic [EN_W-1:0] en_cnt;

  wire launch = (phase == PH_OFF || phase == PH_END) && start;
  assign load_masks = launch;
  assign crc_init   = launch;
  assign eng_req    = (phase == PH_ISSUE);
  assign done       = (phase == PH_END);
  assign crc_step   = (phase == PH_WAIT) && (step == STP_DATA) && eng_rx_valid
                      && (byte_idx < BYTE_W'(BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      step     <= STP_EN_IR;
      en_cnt   <= '0;
      row_idx  <= '0;
      byte_idx <= '0;
    end else begin
      case (phase)
        PH_OFF, PH_END: if (start) begin
          phase   <= PH_ISSUE;
          step    <= STP_EN_IR;
          en_cnt  <= '0;
          row_idx <= '0;
        end
        PH_ISSUE: begin
          phase    <= PH_WAIT;
          byte_idx <= '0;
        end
        default: begin
          if (crc_step) byte_idx <= byte_idx + 1'b1;
          if (eng_ack) begin
            phase <= PH_ISSUE;
            case (step)
              STP_EN_IR:   step <= STP_EN_IDLE;
              STP_EN_IDLE: begin
                if (en_cnt == EN_W'(EN_REPEAT - 1)) step <= STP_RD_IR;
                else begin
                  en_cnt <= en_cnt + 1'b1;
                  step   <= STP_EN_IR;
                end
              end
              STP_RD_IR:     step <= STP_ADDR;
              STP_ADDR:      step <= STP_ADDR_IDLE;
              STP_ADDR_IDLE: step <= STP_DATA;
              STP_DATA:      step <= STP_DATA_IDLE;
              default: begin
                if (row_idx == ROW_W'(ROWS - 1)) phase <= PH_END;
                else begin
                  row_idx <= row_idx + 1'b1;
                  step    <= STP_ADDR;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  // Command contents per step
  always_comb begin
    eng_op    = OP_IDLE;
    eng_len   = 16'(ROW_WAIT);
    eng_data  = 8'h00;
    eng_pause = 8'h00;
    eng_ones  = 1'b0;
    case (step)
      STP_EN_IR:   begin eng_op = OP_IR; eng_len = 16'd8; eng_data = EN_CODE; end
      STP_EN_IDLE: eng_len = 16'(EN_WAIT);
      STP_RD_IR:   begin eng_op = OP_IR; eng_len = 16'd8; eng_data = RD_CODE; eng_pause = 8'd1; end
      STP_ADDR: begin
        eng_op    = OP_DR;
        eng_len   = 16'd7;
        eng_data  = {1'b0, row_gray(int'(row_idx))};
        eng_pause = 8'(ADDR_PAUSE);
      end
      STP_DATA: begin
        eng_op   = OP_DR;
        eng_len  = 16'(ROW_BITS);
        eng_data = 8'hFF;
        eng_ones = 1'b1;
      end
      default: ;
    endcase
  end

  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !eng_req);
  assert_ones_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_ones) |-> (eng_op == OP_DR && eng_len == 16'(ROW_BITS)));
  assert_idle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op == OP_IDLE) |-> (eng_len == 16'(EN_WAIT) || eng_len == 16'(ROW_WAIT)));

endmodule

// File: rtl/row_readback_crc.sv
module row_readback_crc #(
  parameter int ROWS        = 4,
  parameter int ROW_BITS    = 20,
  parameter int NUM_MASKS   = 2,
  parameter int IDX_W       = 1,
  parameter int EN_REPEAT   = 3,
  parameter int EN_WAIT     = 800,
  parameter int ROW_WAIT    = 100,
  parameter int ADDR_PAUSE  = 20,
  localparam int BYTES      = (ROW_BITS + 7) / 8,
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int BYTE_W     = $clog2(BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [NUM_MASKS*BYTES*8-1:0] mask_bank,
  input  logic [ROWS*IDX_W-1:0]        mask_pick,
  output logic                         eng_req,
  output logic [1:0]                   eng_op,
  output logic [15:0]                  eng_len,
  output logic [7:0]                   eng_data,
  output logic [7:0]                   eng_pause,
  output logic                         eng_ones,
  input  logic                         eng_ack,
  input  logic                         eng_rx_valid,
  input  logic [7:0]                   eng_rx_byte,
  output logic                         done,
  output logic [31:0]                  digest
);
  logic              load_masks, crc_init, crc_step;
  logic [ROW_W-1:0]  row_idx;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        mask_byte;
  logic [7:0]        masked_byte;

  rbc_seq #(
    .ROWS(ROWS), .ROW_BITS(ROW_BITS), .EN_REPEAT(EN_REPEAT), .EN_WAIT(EN_WAIT),
    .ROW_WAIT(ROW_WAIT), .ADDR_PAUSE(ADDR_PAUSE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .eng_ack(eng_ack),
    .eng_rx_valid(eng_rx_valid), .eng_req(eng_req), .eng_op(eng_op),
    .eng_len(eng_len), .eng_data(eng_data), .eng_pause(eng_pause),
    .eng_ones(eng_ones), .done(done), .load_masks(load_masks),
    .crc_init(crc_init), .crc_step(crc_step), .row_idx(row_idx), .byte_idx(byte_idx)
  );

  rbc_mask_store #(
    .ROWS(ROWS), .BYTES(BYTES), .NUM_MASKS(NUM_MASKS), .IDX_W(IDX_W)
  ) mask_i (
    .clk(clk), .rst_n(rst_n), .load(load_masks), .bank_in(mask_bank),
    .pick_in(mask_pick), .row_idx(row_idx), .byte_idx(byte_idx), .mask_byte(mask_byte)
  );

  assign masked_byte = eng_rx_byte & mask_byte;

  rbc_crc32 crc_i (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .step(crc_step),
    .data(masked_byte), .digest(digest)
  );

  assert_digest_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(digest));

endmodule

// File: tb/row_readback_crc_tb_top.sv
`timescale 1ns/1ps
module row_readback_crc_tb_top;
  localparam int ROWS = 4, BITS = 20, NM = 2, IDXW = 1;
  localparam int BYTES = (BITS + 7) / 8;
  localparam int CMDS = 2 * 3 + 1 + 4 * ROWS;
  localparam int BW = NM * BYTES * 8;

  // Vector table: seed, mask bank {m1 b2 b1 b0, m0 b2 b1 b0}, per-row pick
  localparam logic [7:0]    SEEDS [4] = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
  localparam logic [BW-1:0] BANKS [4] = '{48'h0FFFFF_0FFFFF, 48'h03F00F_0FFFFF,
                                          48'hFFFFFF_000000, 48'h0F7EFF_0FC35A};
  localparam logic [3:0]    PICKS [4] = '{4'b0000, 4'b1010, 4'b0101, 4'b0110};

  logic clk = 0, rst_n = 0, start = 0;
  logic [BW-1:0] mask_bank = '0;
  logic [ROWS*IDXW-1:0] mask_pick = '0;
  logic eng_req, eng_ones, eng_ack = 0, eng_rx_valid = 0, done;
  logic [1:0] eng_op;
  logic [15:0] eng_len;
  logic [7:0] eng_data, eng_pause, eng_rx_byte = 0;
  logic [31:0] digest;

  row_readback_crc #(.ROWS(ROWS), .ROW_BITS(BITS), .NUM_MASKS(NM), .IDX_W(IDXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_bank(mask_bank), .mask_pick(mask_pick),
    .eng_req(eng_req), .eng_op(eng_op), .eng_len(eng_len), .eng_data(eng_data),
    .eng_pause(eng_pause), .eng_ones(eng_ones), .eng_ack(eng_ack),
    .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte), .done(done), .digest(digest));

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input logic [7:0] seed, input int r, input int b);
    logic [7:0] x;
    x = seed ^ 8'(r * 29) ^ 8'(b * 71) ^ 8'(r * b * 13 + 51);
    if (b == BYTES - 1 && (BITS % 8) != 0) x = x | ~8'((1 << (BITS % 8)) - 1);
    return x;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] x);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ x[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic logic [31:0] exp_digest(input logic [7:0] seed, input logic [BW-1:0] bank,
                                             input logic [3:0] pick);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < BYTES; b++) begin
        int m;
        m = int'(pick[r]);
        c = ref_crc(c, model_byte(seed, r, b) & bank[(m * BYTES + b) * 8 +: 8]);
      end
    return ~c;
  endfunction

  // {op, len, data, pause, ones}; data zeroed where it does not matter
  function automatic logic [63:0] exp_cmd(input int k);
    int j, r, s;
    if (k < 6) return (k % 2 == 0) ? {29'd0, 2'd0, 16'd8, 8'hE8, 8'd0, 1'b0}
                                   : {29'd0, 2'd2, 16'd800, 8'h00, 8'd0, 1'b0};
    if (k == 6) return {29'd0, 2'd0, 16'd8, 8'hEE, 8'd1, 1'b0};
    j = k - 7; r = j / 4; s = j % 4;
    case (s)
      0: return {29'd0, 2'd1, 16'd7, 8'(r ^ (r >> 1)), 8'd20, 1'b0};
      2: return {29'd0, 2'd1, 16'(BITS), 8'h00, 8'd0, 1'b1};
      default: return {29'd0, 2'd2, 16'd100, 8'h00, 8'd0, 1'b0};
    endcase
  endfunction

  logic [63:0] cmd_log [64];
  int cmd_n = 0, req_cycles = 0, rd_row = 0;
  logic [7:0] cur_seed = 0;
  bit extra_byte = 0;

  always @(negedge clk) if (rst_n && eng_req) req_cycles++;

  // Scan engine model
  initial begin
    forever begin
      @(negedge clk);
      eng_ack = 0;
      if (rst_n && eng_req) begin
        logic [7:0] d;
        d = (eng_op == 2'd2 || eng_ones) ? 8'h00 : eng_data;
        if (cmd_n < 64) cmd_log[cmd_n] = {29'd0, eng_op, eng_len, d, eng_pause, eng_ones};
        cmd_n++;
        if (eng_op == 2'd1 && eng_ones) begin
          for (int b = 0; b < BYTES + (extra_byte ? 1 : 0); b++) begin
            @(negedge clk);
            eng_rx_valid = 1;
            eng_rx_byte = (b < BYTES) ? model_byte(cur_seed, rd_row, b) : 8'hC7;
          end
          rd_row++;
          @(negedge clk);
          eng_rx_valid = 0;
        end else begin
          repeat (2) @(negedge clk);
        end
        eng_ack = 1;
      end
    end
  end

  task automatic run(input int v, input bit busy_start, input bit wiggle, input bit extra);
    int guard;
    mask_bank = BANKS[v]; mask_pick = PICKS[v]; cur_seed = SEEDS[v]; extra_byte = extra;
    cmd_n = 0; req_cycles = 0; rd_row = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (wiggle) begin mask_bank = ~BANKS[v]; mask_pick = ~PICKS[v]; end
    if (busy_start) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done == 1'b1, "R8", "watchdog/done", 64'(done), 64'd1);
    repeat (2) @(negedge clk);
    check(cmd_n == CMDS, "R11", "command count", 64'(cmd_n), 64'(CMDS));
    check(req_cycles == CMDS, "R11", "request pulses", 64'(req_cycles), 64'(CMDS));
    for (int k = 0; k < CMDS && k < cmd_n; k++) begin
      string rq;
      rq = (k < 6) ? "R2" : (k == 6) ? "R3" : (((k - 7) % 4) < 2) ? "R4" : "R5";
      check(cmd_log[k] == exp_cmd(k), rq, $sformatf("command %0d", k), cmd_log[k], exp_cmd(k));
    end
    check(digest == exp_digest(SEEDS[v], BANKS[v], PICKS[v]), "R6",
          $sformatf("digest vector %0d (R7 full bytes)", v),
          64'(digest), 64'(exp_digest(SEEDS[v], BANKS[v], PICKS[v])));
  endtask

  initial begin
    logic [31:0] c, held;
    string s;
    // Reference model sanity: standard check value
    c = 32'hFFFFFFFF; s = "123456789";
    for (int i = 0; i < 9; i++) c = ref_crc(c, 8'(s[i]));
    check(~c == 32'hCBF43926, "R7", "model check value", 64'(~c), 64'hCBF43926);

    repeat (3) @(negedge clk);
    check(done == 0, "R1", "done after reset", 64'(done), 0);
    check(eng_req == 0, "R1", "req during reset", 64'(eng_req), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(done == 0 && eng_req == 0, "R1", "idle before start", 64'({done, eng_req}), 0);

    for (int v = 0; v < 4; v++) run(v, 0, 0, 0);

    // R8: result holds
    held = digest;
    repeat (10) @(negedge clk);
    check(done == 1 && digest == held, "R8", "hold after done", 64'({done, digest}), 64'({1'b1, held}));

    run(1, 1, 0, 0);  // R9: start while busy
    run(3, 0, 1, 0);  // R10: mask inputs change mid-run
    run(2, 0, 0, 1);  // R7: surplus byte ignored

    // R1: reset mid-run
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (15) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(done == 0 && eng_req == 0, "R1", "reset mid-run", 64'({done, eng_req}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule